// File: doc/BRIEF.md
# Accumulator Execute and Skip Unit

This block is the execute stage of a small 8-bit accumulator machine. It holds the working register (the accumulator), a 32-entry by 8-bit register file and a zero flag. It executes four single-word register-file operations: clear the accumulator, clear a register, invert a register, and test one bit of a register and skip if that bit is set. The fetch and decode stage in front of it supplies an already decoded operation code, a 5-bit register address, a 3-bit bit index and a destination select bit.

The bit-test operation never redirects the program counter. When the tested bit is 1, the unit raises a flush signal toward fetch for one cycle. During that cycle it discards the instruction that fetch had already prefetched, so the test-and-skip takes two cycles in total. A combinational read port lets the surrounding pipeline, or a bench, observe any register-file entry. The reset contents of the register file are set by two parameters. With the default values every entry resets to zero.

Top module: `acc_exec_unit`

## Requirements
- R1: While reset is held and just after it is released, the accumulator reads 00h, the zero flag is 0 and the flush output is 0. Each register-file entry i reads ((i*RST_MUL) XOR RST_XOR) truncated to 8 bits.
- R2: Operation code 1 (clear accumulator) writes 00h to the accumulator and sets the zero flag. Both are visible after the clock edge that accepts it.
- R3: Operation code 2 (clear register) writes 00h to the addressed entry and sets the zero flag. The accumulator is unchanged.
- R4: Operation code 3 (invert register) with the destination bit at 0 writes the bitwise inverse of the addressed entry to the accumulator. The entry is unchanged.
- R5: Operation code 3 with the destination bit at 1 writes the inverse back to the addressed entry. The accumulator is unchanged.
- R6: After operation code 3, the zero flag is 1 exactly when the 8-bit result is 00h.
- R7: Operation code 4 (bit test) with the selected bit of the addressed entry at 1 raises the flush output for exactly the one following cycle. It changes neither the zero flag, nor the accumulator, nor any entry.
- R8: Operation code 4 with the selected bit at 0 leaves the flush output low, and the instruction in the next cycle executes normally.
- R9: Any instruction presented while the flush output is high is discarded: the accumulator, the zero flag and all entries keep their values, and a bit test in that slot does not raise flush again.
- R10: With the valid input low, or with operation code 0, 5, 6 or 7, nothing changes.
- R11: The read port shows the entry selected by the read address combinationally, and it includes every write accepted at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An instruction is presented this cycle |
| op_code | input | 3 | Decoded operation (0 none, 1 clear acc, 2 clear reg, 3 invert, 4 bit test) |
| op_addr | input | 5 | Register-file address of the operand |
| op_bit | input | 3 | Bit index for the bit test |
| op_dest | input | 1 | Invert destination: 0 accumulator, 1 register |
| rd_addr | input | 5 | Observation read address |
| rd_data | output | 8 | Contents of the entry at rd_addr |
| acc_out | output | 8 | Accumulator contents |
| zero_flag | output | 1 | Zero status flag |
| skip_flush | output | 1 | Discard the prefetched instruction this cycle |

## Verification
The checker assumes that op_code carries only the listed codes or the ignored values 5 to 7. It also assumes that fetch keeps presenting instructions while skip_flush is high, and that op_valid is a clean level that is sampled at each rising edge. The random stimulus draws every field from its full range, including the ignored codes and idle cycles. It changes inputs only on falling edges, so every assumption holds. The directed cases place a bit test in the flush slot and invert an entry that holds FFh, which drives the zero flag both ways.

// File: rtl/acc_exec_pkg.sv
`timescale 1ns/1ps
package acc_exec_pkg;
   typedef enum logic [2:0] {
      OP_IDLE     = 3'd0,
      OP_ACC_ZERO = 3'd1,
      OP_REG_ZERO = 3'd2,
      OP_REG_INV  = 3'd3,
      OP_BIT_SKIP = 3'd4
   } acc_op_e;

   typedef struct packed {
      logic acc_we;
      logic reg_we;
      logic flag_we;
      logic flag_val;
      logic skip_hit;
   } acc_ctl_t;
endpackage

// File: rtl/acc_exec_rf.sv
`timescale 1ns/1ps
module acc_exec_rf #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned RST_MUL = 0,
   parameter int unsigned RST_XOR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] ra_addr,
   output logic [DATA_W-1:0] ra_data,
   input  logic [ADDR_W-1:0] rb_addr,
   output logic [DATA_W-1:0] rb_data
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DEPTH*DATA_W-1:0] flat;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      localparam int unsigned  RV_I = (i * RST_MUL) ^ RST_XOR;
      localparam logic [31:0]  RV_V = RV_I;
      localparam logic [DATA_W-1:0] RV = RV_V[DATA_W-1:0];
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= RV;
         else if (wr_en && (wr_addr == ADDR_W'(i)))
            q <= wr_data;
      end
      assign flat[i*DATA_W +: DATA_W] = q;
   end

   assign ra_data = flat[ra_addr*DATA_W +: DATA_W];
   assign rb_data = flat[rb_addr*DATA_W +: DATA_W];
endmodule

// File: rtl/acc_exec_alu.sv
`timescale 1ns/1ps
module acc_exec_alu
   import acc_exec_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned BIT_W  = 3
) (
   input  acc_op_e           op,
   input  logic [DATA_W-1:0] operand,
   input  logic [BIT_W-1:0]  bit_sel,
   input  logic              dest_reg,
   output logic [DATA_W-1:0] result,
   output acc_ctl_t          ctl
);
   always_comb begin
      result = '0;
      ctl    = '0;
      unique case (op)
         OP_ACC_ZERO: begin
            ctl.acc_we   = 1'b1;
            ctl.flag_we  = 1'b1;
            ctl.flag_val = 1'b1;
         end
         OP_REG_ZERO: begin
            ctl.reg_we   = 1'b1;
            ctl.flag_we  = 1'b1;
            ctl.flag_val = 1'b1;
         end
         OP_REG_INV: begin
            result       = ~operand;
            ctl.acc_we   = ~dest_reg;
            ctl.reg_we   = dest_reg;
            ctl.flag_we  = 1'b1;
            ctl.flag_val = (result == '0);
         end
         OP_BIT_SKIP: begin
            ctl.skip_hit = operand[bit_sel];
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/acc_exec_skip.sv
`timescale 1ns/1ps
module acc_exec_skip (
   input  logic clk,
   input  logic rst_n,
   input  logic issue,
   input  logic hit,
   output logic flush
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flush <= 1'b0;
      else        flush <= issue & hit;
   end
endmodule

// File: rtl/acc_exec_unit.sv
`timescale 1ns/1ps
module acc_exec_unit
   import acc_exec_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned RST_MUL = 0,
   parameter int unsigned RST_XOR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [$clog2(DATA_W)-1:0] op_bit,
   input  logic              op_dest,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] acc_out,
   output logic              zero_flag,
   output logic              skip_flush
);
   localparam int unsigned BIT_W = $clog2(DATA_W);

   if (DATA_W != (1 << BIT_W)) begin : g_bad_width
      $error("acc_exec_unit: DATA_W must be a power of two");
   end
   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
      $error("acc_exec_unit: ADDR_W out of range");
   end

   logic [DATA_W-1:0] operand;
   logic [DATA_W-1:0] result;
   acc_ctl_t          ctl;
   logic              issue;

   assign issue = op_valid & ~skip_flush;

   acc_exec_rf #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .RST_MUL(RST_MUL), .RST_XOR(RST_XOR)
   ) u_rf (
      .clk(clk), .rst_n(rst_n),
      .wr_en(issue & ctl.reg_we), .wr_addr(op_addr), .wr_data(result),
      .ra_addr(op_addr), .ra_data(operand),
      .rb_addr(rd_addr), .rb_data(rd_data)
   );

   acc_exec_alu #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_alu (
      .op(acc_op_e'(op_code)), .operand(operand), .bit_sel(op_bit),
      .dest_reg(op_dest), .result(result), .ctl(ctl)
   );

   acc_exec_skip u_skip (
      .clk(clk), .rst_n(rst_n), .issue(issue), .hit(ctl.skip_hit),
      .flush(skip_flush)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_out   <= '0;
         zero_flag <= 1'b0;
      end else if (issue) begin
         if (ctl.acc_we)  acc_out   <= result;
         if (ctl.flag_we) zero_flag <= ctl.flag_val;
      end
   end
endmodule

// File: rtl/acc_exec_chk.sv
`timescale 1ns/1ps
module acc_exec_chk
   import acc_exec_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [2:0]        op_code,
   input logic              op_dest,
   input logic [DATA_W-1:0] acc_out,
   input logic              zero_flag,
   input logic              skip_flush
);
   logic go;
   assign go = op_valid && !skip_flush;

   p_acc_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (go && op_code == OP_ACC_ZERO) |=> (acc_out == '0 && zero_flag));

   p_clr_reg_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (go && op_code == OP_REG_ZERO) |=> (zero_flag && $stable(acc_out)));

   p_inv_reg_keeps_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (go && op_code == OP_REG_INV && op_dest) |=> $stable(acc_out));

   p_inv_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (go && op_code == OP_REG_INV && !op_dest) |=> (zero_flag == (acc_out == '0)));

   p_test_keeps_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (go && op_code == OP_BIT_SKIP) |=> ($stable(acc_out) && $stable(zero_flag)));

   p_flush_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      skip_flush |-> $past(go && op_code == OP_BIT_SKIP));

   p_flush_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      skip_flush |=> !skip_flush);

   p_flush_slot_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      skip_flush |=> ($stable(acc_out) && $stable(zero_flag)));

   p_idle_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid) |=> ($stable(acc_out) && $stable(zero_flag) && !skip_flush));
endmodule

bind acc_exec_unit acc_exec_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
   .op_dest(op_dest), .acc_out(acc_out), .zero_flag(zero_flag),
   .skip_flush(skip_flush)
);

// File: tb/sim_acc_exec_unit.sv
`timescale 1ns/1ps
module sim_acc_exec_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [2:0] op_code = 3'd0;
   logic [4:0] op_addr = 5'd0;
   logic [2:0] op_bit = 3'd0;
   logic       op_dest = 1'b0;
   logic [4:0] rd_addr = 5'd0;
   logic [7:0] rd_data, acc_out;
   logic       zero_flag, skip_flush;

   int checks = 0;
   int errors = 0;
   logic done = 1'b0;

   logic [7:0] m_reg [32];
   logic [7:0] m_acc;
   logic       m_z;
   logic       m_skip;

   always #5 clk = ~clk;

   acc_exec_unit #(.RST_MUL(37), .RST_XOR(32'h5A)) u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_addr(op_addr), .op_bit(op_bit), .op_dest(op_dest),
      .rd_addr(rd_addr), .rd_data(rd_data), .acc_out(acc_out),
      .zero_flag(zero_flag), .skip_flush(skip_flush)
   );

   function automatic logic [7:0] rst_val(input int i);
      int t;
      t = (i * 37) ^ 32'h5A;
      return t[7:0];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 32; i++) m_reg[i] = rst_val(i);
      m_acc = 8'h00; m_z = 1'b0; m_skip = 1'b0;
   endtask

   // model of one accepted edge, from the requirements
   task automatic model_step(input logic v, input logic [2:0] c, input logic [4:0] a,
                             input logic [2:0] b, input logic d);
      logic nskip;
      logic [7:0] inv;
      nskip = 1'b0;
      if (v && !m_skip) begin
         inv = ~m_reg[a];
         case (c)
            3'd1: begin m_acc = 8'h00; m_z = 1'b1; end
            3'd2: begin m_reg[a] = 8'h00; m_z = 1'b1; end
            3'd3: begin
               if (d) m_reg[a] = inv; else m_acc = inv;
               m_z = (inv == 8'h00);
            end
            3'd4: nskip = m_reg[a][b];
            default: ;
         endcase
      end
      m_skip = nskip;
   endtask

   task automatic issue(input logic v, input logic [2:0] c, input logic [4:0] a,
                        input logic [2:0] b, input logic d, input string req);
      @(negedge clk);
      op_valid = v; op_code = c; op_addr = a; op_bit = b; op_dest = d; rd_addr = a;
      @(posedge clk);
      #1;
      model_step(v, c, a, b, d);
      check({req, " acc"}, 32'(acc_out), 32'(m_acc));
      check({req, " zero"}, 32'(zero_flag), 32'(m_z));
      check({req, " flush"}, 32'(skip_flush), 32'(m_skip));
      check({req, " R11 entry"}, 32'(rd_data), 32'(m_reg[a]));
   endtask

   task automatic sweep(input string req);
      for (int i = 0; i < 32; i++) begin
         rd_addr = 5'(i);
         #1;
         check(req, 32'(rd_data), 32'(m_reg[i]));
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check("R1 acc", 32'(acc_out), 32'h0);
      check("R1 zero", 32'(zero_flag), 32'h0);
      check("R1 flush", 32'(skip_flush), 32'h0);
      sweep("R1 reset entry");
      @(negedge clk);
      rst_n = 1'b1;

      // R2 clear accumulator after invert leaves it nonzero
      issue(1, 3'd3, 5'd1, 0, 0, "R4 invert to acc");
      issue(1, 3'd1, 5'd0, 0, 0, "R2 clear acc");
      // R3 clear register, then R5 invert back gives FFh
      issue(1, 3'd3, 5'd2, 0, 0, "R4 acc nonzero");
      issue(1, 3'd2, 5'd3, 0, 0, "R3 clear reg");
      issue(1, 3'd3, 5'd3, 0, 1, "R5 invert to reg");
      // R6 invert of FFh gives zero flag 1
      issue(1, 3'd3, 5'd3, 0, 0, "R6 zero result");
      issue(1, 3'd3, 5'd4, 0, 0, "R6 nonzero result");
      // R7 bit test hit, flush slot holds clear-acc that must be dropped (R9)
      issue(1, 3'd4, 5'd3, 3'd5, 0, "R7 bit set");
      check("R7 flush high", 32'(skip_flush), 32'h1);
      issue(1, 3'd1, 5'd0, 0, 0, "R9 discarded clear acc");
      check("R9 flush single", 32'(skip_flush), 32'h0);
      // R9 bit test placed in the flush slot does not skip again
      issue(1, 3'd4, 5'd3, 3'd0, 0, "R7 bit set again");
      issue(1, 3'd4, 5'd3, 3'd1, 0, "R9 test in flush slot");
      check("R9 no second flush", 32'(skip_flush), 32'h0);
      // R8 bit clear: next instruction executes
      issue(1, 3'd4, 5'd0, 3'd0, 0, "R8 bit clear");
      check("R8 flush low", 32'(skip_flush), 32'h0);
      issue(1, 3'd1, 5'd0, 0, 0, "R8 following executes");
      // R10 ignored codes and invalid cycles
      issue(1, 3'd3, 5'd5, 0, 0, "R10 setup");
      issue(1, 3'd7, 5'd5, 0, 1, "R10 code 7");
      issue(1, 3'd0, 5'd5, 0, 1, "R10 code 0");
      issue(0, 3'd2, 5'd5, 0, 0, "R10 valid low");
      sweep("R10 entries kept");

      for (int n = 0; n < 2000; n++) begin
         issue(($urandom % 10) != 0, 3'($urandom % 8), 5'($urandom),
               3'($urandom), 1'($urandom), "R11 random");
      end
      sweep("R11 final entries");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule